// File: doc/BRIEF.md
# FM Rhythm Phase Generator

This block produces the waveform-table phases for three rhythm voices of an FM synthesis engine: hi-hat, snare and cymbal. Unlike melodic voices, these phases are not the raw output of a phase accumulator. They are built from a few bits of two accumulators (the hi-hat operator and the cymbal operator) combined with a pseudo-random noise bit.

Three operator phase accumulators (hi-hat, snare, cymbal) advance once per sample tick. Each adds its frequency increment plus a vibrato correction, which is the increment multiplied by a signed vibrato offset and scaled down by the fraction width. On the same tick the rhythm phases are formed from the accumulator values held before the advance. They are registered and held until the next tick. A 23-bit linear-feedback shift register supplies the noise bit and steps once per tick. Waveform lookup and envelope shaping are done downstream.

Top module: `rhythm_phase_gen`

## Requirements
- R1: The mix bit is `(c1[7]^c1[2]) | c1[3] | (c3[5]^c3[3])`. Here c1 is the 10-bit integer part of the hi-hat accumulator (bits 19:10) and c3 is that of the cymbal accumulator.
- R2: On a tick, `hat_phase_o` becomes `(mix<<8) | (10'h034 << s)`, where the 2-bit shift amount `s` has bit 1 equal to the noise bit and bit 0 equal to the mix bit.
- R3: On a tick, `snare_phase_o` becomes `((1 + c1[8]) ^ noise) << 8`, giving one of 0x000, 0x100, 0x200 or 0x300.
- R4: On a tick, `cym_phase_o` becomes 0x200 when the mix bit is 1 and 0x100 when it is 0.
- R5: On a tick, each accumulator adds `inc + floor(inc*vib / 2^10)` modulo 2^20. `vib_i` is a signed two's-complement value. `acc_phase_o` shows the integer parts: hat in [9:0], snare in [19:10], cymbal in [29:20].
- R6: The rhythm phases formed on a tick use the accumulator and noise values from before that tick's advance. They appear in the cycle after the tick, when `acc_phase_o` already shows the advanced values.
- R7: While `tick_i` is low, the accumulators, the noise register and all three rhythm phases hold their values.
- R8: The noise bit is bit 22 of a 23-bit shift register. The register resets to 1 and, on each tick, shifts left, taking `bit22 ^ bit8` into bit 0. It is never zero.
- R9: After reset, all accumulators and all rhythm phase outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample-tick strobe |
| inc_hat_i | input | 20 | Hi-hat operator increment (10.10 fixed point) |
| inc_snare_i | input | 20 | Snare operator increment |
| inc_cym_i | input | 20 | Cymbal operator increment |
| vib_i | input | 8 | Signed vibrato offset, in units of 2^-10 |
| acc_phase_o | output | 30 | Integer parts of the three accumulators |
| hat_phase_o | output | 10 | Hi-hat waveform phase |
| snare_phase_o | output | 10 | Snare waveform phase |
| cym_phase_o | output | 10 | Cymbal waveform phase |

## Verification
The in-RTL assertions check four things on every cycle:
- the accumulators, noise register and rhythm outputs stay still when no tick arrives;
- the noise register never holds zero;
- the cymbal phase only ever takes its two legal codes;
- the bit patterns the hi-hat and snare formulas cannot produce never appear.

Only the bench scenarios can show the rest. These include:
- the exact mix-bit decoding from particular accumulator bits;
- the one-tick lag between the accumulators and the rhythm phases;
- the vibrato scaling, with floor rounding for negative offsets, and wrap-around;
- the tick on which the noise bit first turns on and flips the snare and hi-hat patterns.

The bench makes these visible by comparing against a behavioural model on every clock.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    localparam int PHASE_W = 10;
    localparam int N_OPS   = 3;

    typedef enum int {
        OP_HAT   = 0,
        OP_SNARE = 1,
        OP_CYM   = 2
    } op_sel_e;

    typedef struct packed {
        logic [PHASE_W-1:0] hat;
        logic [PHASE_W-1:0] snare;
        logic [PHASE_W-1:0] cym;
    } rhythm_t;
endpackage

// File: rtl/rpg_accum.sv
module rpg_accum #(
    parameter int ACC_W  = 20,
    parameter int FRAC_W = 10,
    parameter int VIB_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic [ACC_W-1:0]        inc_i,
    input  logic signed [VIB_W-1:0] vib_i,
    output logic [ACC_W-1:0]        acc_o
);
    localparam int PROD_W = ACC_W + 1 + VIB_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] adj;
    logic [ACC_W-1:0]         step;

    always_comb begin
        prod = $signed({1'b0, inc_i}) * vib_i;
        adj  = prod >>> FRAC_W;
        step = inc_i + adj[ACC_W-1:0];
        st_d = st_q;
        if (tick_i) begin
            st_d.acc = st_q.acc + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // R7: no tick, no motion
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(acc_o));
endmodule

// File: rtl/rpg_noise.sv
module rpg_noise #(
    parameter int              LFSR_W = 23,
    parameter int              TAP    = 8,
    parameter logic [LFSR_W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic noise_o
);
    typedef struct packed {
        logic [LFSR_W-1:0] sr;
    } noise_state_t;

    noise_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.sr = {st_q.sr[LFSR_W-2:0], st_q.sr[LFSR_W-1] ^ st_q.sr[TAP]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sr <= SEED;
        else        st_q    <= st_d;
    end

    assign noise_o = st_q.sr[LFSR_W-1];

    // R8: register never collapses to zero
    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);
    // R7: register holds between ticks
    p_lfsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.sr));
endmodule

// File: rtl/rpg_mix.sv
module rpg_mix
    import rpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [PHASE_W-1:0] c1_i,
    input  logic [PHASE_W-1:0] c3_i,
    input  logic               noise_i,
    output rhythm_t            ph_o
);
    rhythm_t    st_d, st_q;
    logic       mix;
    logic [1:0] shamt;
    logic [1:0] sn_base;
    logic [1:0] sn_code;

    always_comb begin
        mix     = (c1_i[7] ^ c1_i[2]) | c1_i[3] | (c3_i[5] ^ c3_i[3]);
        shamt   = {noise_i, mix};
        sn_base = c1_i[8] ? 2'b10 : 2'b01;
        sn_code = sn_base ^ {1'b0, noise_i};
        st_d    = st_q;
        if (tick_i) begin
            st_d.hat   = {1'b0, mix, 8'h00} | (10'h034 << shamt);
            st_d.snare = {sn_code, 8'h00};
            st_d.cym   = mix ? 10'h200 : 10'h100;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_o = st_q;

    // R7: outputs only move on a tick
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(ph_o));
    // R4: cymbal is zero (reset) or one of two codes
    p_cym_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ph_o.cym[7:0] == 8'h00 && ph_o.cym[9:8] != 2'b11);
    // R2: hi-hat never uses bit 9 or the two low bits
    p_hat_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_o.hat[9] == 1'b0 && ph_o.hat[1:0] == 2'b00);
    // R3: snare lives only in the top two bits
    p_snare_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_o.snare[7:0] == 8'h00);
endmodule

// File: rtl/rhythm_phase_gen.sv
module rhythm_phase_gen
    import rpg_pkg::*;
#(
    parameter int FRAC_W    = 10,
    parameter int VIB_W     = 8,
    parameter int LFSR_W    = 23,
    parameter int LFSR_TAP  = 8,
    parameter int LFSR_SEED = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic [PHASE_W+FRAC_W-1:0] inc_hat_i,
    input  logic [PHASE_W+FRAC_W-1:0] inc_snare_i,
    input  logic [PHASE_W+FRAC_W-1:0] inc_cym_i,
    input  logic signed [VIB_W-1:0]   vib_i,
    output logic [N_OPS*PHASE_W-1:0]  acc_phase_o,
    output logic [PHASE_W-1:0]        hat_phase_o,
    output logic [PHASE_W-1:0]        snare_phase_o,
    output logic [PHASE_W-1:0]        cym_phase_o
);
    localparam int ACC_W = PHASE_W + FRAC_W;

    logic [N_OPS-1:0][ACC_W-1:0]   inc_all;
    logic [N_OPS-1:0][ACC_W-1:0]   acc_all;
    logic [N_OPS-1:0][PHASE_W-1:0] int_all;
    logic                          noise;
    rhythm_t                       ph;

    assign inc_all[OP_HAT]   = inc_hat_i;
    assign inc_all[OP_SNARE] = inc_snare_i;
    assign inc_all[OP_CYM]   = inc_cym_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        rpg_accum #(
            .ACC_W (ACC_W),
            .FRAC_W(FRAC_W),
            .VIB_W (VIB_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick_i),
            .inc_i (inc_all[g]),
            .vib_i (vib_i),
            .acc_o (acc_all[g])
        );
        assign int_all[g] = acc_all[g][ACC_W-1:FRAC_W];
    end

    rpg_noise #(
        .LFSR_W(LFSR_W),
        .TAP   (LFSR_TAP),
        .SEED  (LFSR_W'(LFSR_SEED))
    ) u_noise (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .noise_o(noise)
    );

    rpg_mix u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .c1_i   (int_all[OP_HAT]),
        .c3_i   (int_all[OP_CYM]),
        .noise_i(noise),
        .ph_o   (ph)
    );

    assign acc_phase_o   = int_all;
    assign hat_phase_o   = ph.hat;
    assign snare_phase_o = ph.snare;
    assign cym_phase_o   = ph.cym;
endmodule

// File: tb/tb_rhythm_phase_gen.sv
module tb_rhythm_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [19:0] inc_h = '0, inc_s = '0, inc_c = '0;
    logic signed [7:0] vib = '0;
    logic [29:0] accp;
    logic [9:0]  hat, snr, cym;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int m_acc [3];
    int m_lfsr;
    int m_hat, m_snr, m_cym;

    always #2.5 clk = ~clk;

    rhythm_phase_gen dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .inc_hat_i(inc_h), .inc_snare_i(inc_s), .inc_cym_i(inc_c),
        .vib_i(vib), .acc_phase_o(accp),
        .hat_phase_o(hat), .snare_phase_o(snr), .cym_phase_o(cym)
    );

    function automatic int adv(int a, int inc, int v);
        int p;
        p = inc * v;
        return (a + inc + (p >>> 10)) & 32'hFFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_acc[i]) m_acc[i] = 0;
            m_lfsr = 1;
            m_hat = 0; m_snr = 0; m_cym = 0;
        end else if (tick) begin
            int c1, c3, nz, mb;
            c1 = m_acc[0] >> 10;
            c3 = m_acc[2] >> 10;
            nz = (m_lfsr >> 22) & 1;
            mb = ((((c1 >> 7) ^ (c1 >> 2)) & 1) != 0 || ((c1 >> 3) & 1) != 0 ||
                  (((c3 >> 5) ^ (c3 >> 3)) & 1) != 0) ? 1 : 0;
            m_hat = (mb * 256) | ((52 << (nz * 2 + mb)) & 10'h3FF);
            m_snr = (((c1 >> 8) & 1) + 1 ^ nz) * 256;
            m_cym = (1 + mb) * 256;
            m_acc[0] = adv(m_acc[0], int'(inc_h), int'(vib));
            m_acc[1] = adv(m_acc[1], int'(inc_s), int'(vib));
            m_acc[2] = adv(m_acc[2], int'(inc_c), int'(vib));
            m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 22) ^ (m_lfsr >> 8)) & 1)) & 32'h7FFFFF;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R2 hat vs model", int'(hat), m_hat);
            chk("R3 R8 snare vs model", int'(snr), m_snr);
            chk("R1 R4 cym vs model", int'(cym), m_cym);
            chk("R5 R7 acc vs model", int'(accp),
                ((m_acc[2] >> 10) << 20) | ((m_acc[1] >> 10) << 10) | (m_acc[0] >> 10));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0;
        inc_h = '0; inc_s = '0; inc_c = '0; vib = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [9:0] sh, ss, sc;
        // R9 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset hat", int'(hat), 0);
        chk("R9 reset snare", int'(snr), 0);
        chk("R9 reset cym", int'(cym), 0);
        chk("R9 reset acc", int'(accp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R6: first tick from zero accumulators, noise 0
        one_tick();
        chk("R6 hat first tick", int'(hat), 'h034);
        chk("R6 snare first tick", int'(snr), 'h100);
        chk("R6 cym first tick", int'(cym), 'h100);

        // R3 and R6: hi-hat integer 0x100
        do_reset();
        @(negedge clk);
        inc_h = 20'h100 << 10;
        one_tick();
        inc_h = '0;
        chk("R6 acc advanced", int'(accp[9:0]), 'h100);
        chk("R6 snare from pre-advance acc", int'(snr), 'h100);
        one_tick();
        chk("R3 snare with c1 bit8", int'(snr), 'h200);

        // R1: c1 bit3 sets the mix bit
        do_reset();
        @(negedge clk);
        inc_h = 20'h008 << 10;
        one_tick();
        inc_h = '0;
        one_tick();
        chk("R1 hat with mix", int'(hat), 'h168);
        chk("R1 cym with mix", int'(cym), 'h200);

        // R1: c3 bit5 sets the mix bit
        do_reset();
        @(negedge clk);
        inc_c = 20'h020 << 10;
        one_tick();
        inc_c = '0;
        one_tick();
        chk("R1 cym from cymbal acc", int'(cym), 'h200);

        // R8: noise turns on at tick 23 after reset
        do_reset();
        @(negedge clk);
        repeat (22) one_tick();
        chk("R8 snare before noise", int'(snr), 'h100);
        one_tick();
        chk("R8 snare with noise", int'(snr), 'h000);
        chk("R8 hat with noise", int'(hat), 'h0D0);

        // R5: varied increments and vibrato, ticks with gaps
        do_reset();
        @(negedge clk);
        for (int k = 0; k < 600; k++) begin
            inc_h = 20'(32'h0_1A3F + k * 977);
            inc_s = 20'(32'h0_0C11 + k * 4099);
            inc_c = 20'(32'h2_2E71 + k * 313);
            vib   = (k < 200) ? 8'sd0 : (k < 400) ? 8'sd50 : -8'sd100;
            tick  = (k % 3) != 1;
            @(negedge clk);
        end
        tick = 1'b0;

        // R5: wrap with near-full increments
        inc_h = 20'hFFF00; inc_s = 20'hFFFFF; inc_c = 20'hFE001; vib = 8'sd127;
        repeat (40) one_tick();
        vib = -8'sd128;
        repeat (40) one_tick();

        // R7: idle cycles hold everything
        sh = hat; ss = snr; sc = cym;
        inc_h = 20'h12345;
        repeat (6) @(negedge clk);
        chk("R7 hat hold", int'(hat), int'(sh));
        chk("R7 snare hold", int'(snr), int'(ss));
        chk("R7 cym hold", int'(cym), int'(sc));

        // R9: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset hat", int'(hat), 0);
        chk("R9 mid reset acc", int'(accp), 0);
        rst_n = 1'b1;
        repeat (30) one_tick();
        finish_up();
    end
endmodule